// File: doc/BRIEF.md
# Guarded Issue Squash Window

This block sits in the issue stage of a processor that uses guard instructions. A guard carries a condition value, a required polarity and a bit mask. The mask names which of the instructions that come after the guard depend on that condition. The block keeps a short window of squash flags, one for each upcoming instruction slot. Bit 0 of the window belongs to the next instruction that will issue.

Each issue strobe consumes the front of the window and reports, one cycle later, whether that instruction may write architectural state. When a guard's condition disagrees with its polarity, the instructions it selects are marked as squashed. A flag that is set stays set until its instruction issues or a flush clears the window. A later guard can squash more instructions, but it can never bring a squashed one back.

Top module: `guard_mask_unit`

## Requirements
- R1: After reset, `commit_valid` is 0 and every window slot is in the execute state, so the instructions that issue first all report `commit_en` = 1 until a guard squashes something.
- R2: One cycle after a cycle with `issue_valid` = 1, `commit_valid` is 1 and `commit_en` is the inverse of that instruction's squash flag. After a cycle with `issue_valid` = 0, `commit_valid` is 0.
- R3: A guard (`guard_valid` = 1) squashes an instruction when `guard_cond` differs from `guard_pol`. The instructions it squashes are those whose bit k of `guard_mask` is 1, where bit 0 is the first instruction that issues after the guard and bit k is the (k+1)-th.
- R4: A guard whose `guard_cond` equals `guard_pol` leaves the window unchanged.
- R5: Guards only add squashes. A squashed slot stays squashed until its instruction issues or a flush clears the window, even if a later guard selects it with a matching condition.
- R6: Each issue shifts the window by one slot. The slot that enters at the far end (index WIN-1) is in the execute state, so an instruction more than WIN positions after every guard commits.
- R7: If a guard and an issue occur in the same cycle, the instruction that issues takes its verdict from the window as it was before the guard. The guard's mask bit 0 then applies to the next instruction that issues.
- R8: `flush` = 1 clears every slot to execute and discards any guard in the same cycle. An instruction that issues in the flush cycle still takes its verdict from the window as it was before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear the window to all-execute |
| guard_valid | input | 1 | A guard instruction issues this cycle |
| guard_cond | input | 1 | Value of the condition register the guard names |
| guard_pol | input | 1 | Condition value that lets the dependent instructions execute |
| guard_mask | input | WIN | Dependence mask; bit k selects the (k+1)-th following instruction |
| issue_valid | input | 1 | A non-guard instruction issues this cycle |
| commit_valid | output | 1 | Registered: a verdict is presented |
| commit_en | output | 1 | Registered: 1 lets the instruction write state, 0 squashes it |

## Verification
A wrong flag in the window shows up at the ports only when the instruction in that slot issues. The error appears as a wrong `commit_en` one cycle after that issue strobe, which may be as many as WIN issues after the guard that caused it. An alignment mistake, such as an off-by-one on the shift or a guard applied before the same-cycle shift, makes the verdict sequence move by one position. A stuck or revived flag changes a single verdict. To catch these, every verdict is compared with a slot-by-slot model across guard masks, all four condition and polarity pairs, and mixed streams of guards, issues and flushes.

// File: rtl/gm_pkg.sv
package gm_pkg;

  // Squash decision for a guard: true when the condition disagrees with
  // the polarity that would let dependents run.
  function automatic logic guard_squashes(input logic cond, input logic pol);
    return cond ^ pol;
  endfunction

endpackage

// File: rtl/gm_guard_eval.sv
module gm_guard_eval #(
  parameter int WIN = 16
) (
  input  logic           guard_valid,
  input  logic           guard_cond,
  input  logic           guard_pol,
  input  logic [WIN-1:0] guard_mask,
  output logic [WIN-1:0] kill_vec
);
  import gm_pkg::*;

  logic hit;

  always_comb begin
    hit      = guard_valid & guard_squashes(guard_cond, guard_pol);
    kill_vec = hit ? guard_mask : '0;
  end

endmodule

// File: rtl/gm_window.sv
module gm_window #(
  parameter int WIN = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flush,
  input  logic           shift_en,
  input  logic [WIN-1:0] kill_vec,
  output logic [WIN-1:0] win_q
);

  logic [WIN-1:0] win_d;

  generate
    for (genvar i = 0; i < WIN; i++) begin : g_slot
      logic shifted;
      if (i == WIN - 1) begin : g_top
        assign shifted = shift_en ? 1'b0 : win_q[i];
      end else begin : g_body
        assign shifted = shift_en ? win_q[i+1] : win_q[i];
      end
      assign win_d[i] = flush ? 1'b0 : (shifted | kill_vec[i]);

      // R5: with no shift and no flush a squashed slot stays squashed
      p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (!flush && !shift_en && win_q[i]) |=> win_q[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else     win_q <= win_d;
  end

  // R8: a flush leaves an all-execute window
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (win_q == '0));

  // R6: far-end slot enters as execute when nothing kills it
  p_fill_exec_r6: assert property (@(posedge clk) disable iff (rst)
    (!flush && shift_en && !kill_vec[WIN-1]) |=> !win_q[WIN-1]);

endmodule

// File: rtl/gm_commit_out.sv
module gm_commit_out (
  input  logic clk,
  input  logic rst,
  input  logic issue_valid,
  input  logic front_squash,
  output logic commit_valid,
  output logic commit_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_valid <= 1'b0;
      commit_en    <= 1'b0;
    end else begin
      commit_valid <= issue_valid;
      commit_en    <= issue_valid & ~front_squash;
    end
  end

  // R2: a verdict follows every issue strobe by one cycle, and only then
  p_verdict_r2: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> commit_valid);
  p_no_verdict_r2: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> !commit_valid);

endmodule

// File: rtl/guard_mask_unit.sv
module guard_mask_unit #(
  parameter int WIN = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flush,
  input  logic           guard_valid,
  input  logic           guard_cond,
  input  logic           guard_pol,
  input  logic [WIN-1:0] guard_mask,
  input  logic           issue_valid,
  output logic           commit_valid,
  output logic           commit_en
);

  logic [WIN-1:0] kill_vec;
  logic [WIN-1:0] win_q;

  gm_guard_eval #(.WIN(WIN)) u_eval (
    .guard_valid (guard_valid),
    .guard_cond  (guard_cond),
    .guard_pol   (guard_pol),
    .guard_mask  (guard_mask),
    .kill_vec    (kill_vec)
  );

  gm_window #(.WIN(WIN)) u_win (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .shift_en (issue_valid),
    .kill_vec (kill_vec),
    .win_q    (win_q)
  );

  gm_commit_out u_out (
    .clk          (clk),
    .rst          (rst),
    .issue_valid  (issue_valid),
    .front_squash (win_q[0]),
    .commit_valid (commit_valid),
    .commit_en    (commit_en)
  );

  // R4: a guard whose condition matches its polarity changes nothing
  p_match_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (guard_valid && (guard_cond == guard_pol) && !issue_valid && !flush)
      |=> (win_q == $past(win_q)));

  // R7: shift happens before the same-cycle guard is merged
  p_guard_align_r7: assert property (@(posedge clk) disable iff (rst)
    (guard_valid && (guard_cond != guard_pol) && guard_mask[0] && !flush)
      |=> win_q[0]);

endmodule

// File: tb/guard_mask_unit_bench.sv
module guard_mask_unit_bench;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, guard_valid = 1'b0, guard_cond = 1'b0, guard_pol = 1'b0;
  logic [WIN-1:0] guard_mask = '0;
  logic issue_valid = 1'b0;
  logic commit_valid, commit_en;

  int checks = 0;
  int errors = 0;
  int cyc_count = 0;
  logic [WIN-1:0] model = '0;

  always #10 clk = ~clk;

  guard_mask_unit #(.WIN(WIN)) u_guard_mask_unit (
    .clk(clk), .rst(rst), .flush(flush), .guard_valid(guard_valid),
    .guard_cond(guard_cond), .guard_pol(guard_pol), .guard_mask(guard_mask),
    .issue_valid(issue_valid), .commit_valid(commit_valid), .commit_en(commit_en)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_count <= cyc_count + 1;
    if (cyc_count > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected < 100000", cyc_count);
      finish_run();
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, update model, check after the edge.
  task automatic step(input string req, input logic g, input logic c,
                      input logic p, input logic [WIN-1:0] m,
                      input logic iss, input logic fl);
    logic exp_en;
    guard_valid = g; guard_cond = c; guard_pol = p; guard_mask = m;
    issue_valid = iss; flush = fl;
    exp_en = iss & ~model[0];
    if (fl) model = '0;
    else begin
      if (iss) model = model >> 1;
      if (g && (c != p)) model = model | m;
    end
    @(posedge clk); #1;
    check({req, " valid"}, commit_valid, iss);
    if (iss) check({req, " en"}, commit_en, exp_en);
    @(negedge clk);
    guard_valid = 1'b0; issue_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic drain(input string req, input int n);
    for (int k = 0; k < n; k++) step(req, 1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 reset valid", commit_valid, 1'b0);
    drain("R1 first issues", WIN);

    // R3/R4/R6: every cond/pol pair over a set of masks
    for (int cp = 0; cp < 4; cp++) begin
      for (int mi = 0; mi < 12; mi++) begin
        logic [WIN-1:0] m;
        m = WIN'((mi * 37 + 5) ^ (1 << (mi % WIN)));
        step((cp[1] != cp[0]) ? "R3 guard" : "R4 match",
             1'b1, cp[1], cp[0], m, 1'b0, 1'b0);
        drain("R6 drain", WIN + 2);
      end
    end

    // R5: squash then matching guard cannot revive
    step("R5 kill", 1'b1, 1'b1, 1'b0, 8'b0000_0101, 1'b0, 1'b0);
    step("R5 revive try", 1'b1, 1'b1, 1'b1, 8'b1111_1111, 1'b0, 1'b0);
    step("R5 add", 1'b1, 1'b0, 1'b1, 8'b0000_1000, 1'b0, 1'b0);
    drain("R5 sticky", WIN);

    // R7: guard with issue in the same cycle
    step("R7 pre", 1'b1, 1'b0, 1'b1, 8'b0000_0001, 1'b0, 1'b0);
    step("R7 same cycle", 1'b1, 1'b0, 1'b1, 8'b0000_0010, 1'b1, 1'b0);
    drain("R7 aligned", 4);

    // R8: flush with guard and issue
    step("R8 load", 1'b1, 1'b1, 1'b0, 8'b1111_1111, 1'b0, 1'b0);
    step("R8 flush+issue", 1'b1, 1'b1, 1'b0, 8'b1111_1111, 1'b1, 1'b1);
    drain("R8 cleared", WIN);

    // Mixed stream, R2 through R8
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R2 mixed", lfsr[3:2] == 2'b00, lfsr[4], lfsr[5], lfsr[15:8],
           lfsr[7:6] != 2'b00, lfsr[20:16] == 5'd0);
    end
    step("R2 idle", 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    finish_run();
  end
endmodule